// File: doc/BRIEF.md
# Two-Rail Transition Line Encoder

This block turns a serial bit stream into levels on two binary wires. It guarantees that at least one wire changes level in every baud interval. The clock rail inverts on every interval whatever the data. The data rail is NRZI-coded: it inverts for a 1 and holds its level for a 0. Because every interval carries a transition, a receiver can recover timing and data even when the two wires are crossed, or when either of them is inverted.

The encoder takes one data bit per clock cycle. Both rails are registered and have no combinational path from the data input. After reset, a short shift-chain sequence keeps both rails at 0 for a fixed number of edges before encoding begins. Data offered during that sequence is discarded. The length of the sequence is set by a parameter whose default is two stages.

Top module: `twoRailEncoder`

## Requirements
- R1: While `rst` is high, `clockRail` and `dataRail` are both 0.
- R2: After `rst` falls, the first two rising edges of `clk` leave both rails at 0, whatever the value of `dataIn`. Data offered on those edges is discarded.
- R3: From the third rising edge after `rst` falls, `clockRail` inverts on every rising edge.
- R4: From that point on, `dataRail` inverts on a rising edge at which `dataIn` is sampled as 1.
- R5: From that point on, `dataRail` keeps its level on a rising edge at which `dataIn` is sampled as 0.
- R6: Outside the reset sequence, every rising edge changes at least one of the two rails. An edge that leaves both rails unchanged never occurs.
- R7: Raising `rst` in the middle of a stream returns both rails to 0 at once. The full two-edge sequence of R2 then repeats after release.
- R8: A change on `dataIn` between rising edges does not change either rail until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Baud clock; one data bit per rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| dataIn | input | 1 | Serial data bit, sampled on the rising edge |
| clockRail | output | 1 | Line that inverts on every active interval |
| dataRail | output | 1 | NRZI-coded data line |

## Verification
The clock-rail toggle and the NRZI data toggle can fall in the same edge whenever the sampled bit is 1. A bit of 0 leaves the clock rail as the only transition in that interval. Runs of ones, runs of zeros, alternating bits and a pseudo-random stream provoke both cases. A scoreboard model judges each edge against its expected pair of levels and, on every active edge, separately checks that the pair changed. The reset sequence is also run against a 1 on the data input, and a reset is raised mid-stream, to show that data cannot leak into the rails before the sequence ends.

// File: rtl/twoRailPkg.sv
package twoRailPkg;

  // Strobes the control half hands to the datapath each cycle.
  typedef struct packed {
    logic hold;     // reset sequence running: force rails low
    logic advance;  // encode one baud interval
  } railStrobeT;

endpackage

// File: rtl/twoRailCtrl.sv
module twoRailCtrl
  import twoRailPkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  output railStrobeT strobe
);

  logic [RST_STAGES-1:0] seqChain;
  logic                  seqBusy;

  // Shift chain: loads all ones in reset, then shifts zeros in.
  generate
    if (RST_STAGES == 1) begin : g_single
      always_ff @(posedge clk or posedge rst) begin
        if (rst) seqChain <= 1'b1;
        else     seqChain <= 1'b0;
      end
    end else begin : g_chain
      always_ff @(posedge clk or posedge rst) begin
        if (rst) seqChain <= '1;
        else     seqChain <= {seqChain[RST_STAGES-2:0], 1'b0};
      end
    end
  endgenerate

  assign seqBusy        = |seqChain;
  assign strobe.hold    = seqBusy;
  assign strobe.advance = ~seqBusy;

  // Once the sequence has ended it cannot restart without rst.
  AST_SEQ_ONE_WAY: assert property (@(posedge clk) disable iff (rst)
    !strobe.hold |=> !strobe.hold);  // R2

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $onehot(strobe));  // R6

endmodule

// File: rtl/twoRailData.sv
module twoRailData
  import twoRailPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dataIn,
  input  railStrobeT strobe,
  output logic       clockRail,
  output logic       dataRail
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      clockRail <= 1'b0;
      dataRail  <= 1'b0;
    end else if (strobe.hold) begin
      clockRail <= 1'b0;
      dataRail  <= 1'b0;
    end else if (strobe.advance) begin
      clockRail <= ~clockRail;
      dataRail  <= dataRail ^ dataIn;
    end
  end

  AST_RST_LOW: assert property (@(posedge clk)
    rst |-> (clockRail == 1'b0 && dataRail == 1'b0));  // R1

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
    strobe.hold |=> (clockRail == 1'b0 && dataRail == 1'b0));  // R2

  AST_CLOCK_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    strobe.advance |=> clockRail != $past(clockRail));  // R3

  AST_NRZI_ONE: assert property (@(posedge clk) disable iff (rst)
    (strobe.advance && dataIn) |=> dataRail != $past(dataRail));  // R4

  AST_NRZI_ZERO: assert property (@(posedge clk) disable iff (rst)
    (strobe.advance && !dataIn) |=> $stable(dataRail));  // R5

  AST_NO_IDLE_EDGE: assert property (@(posedge clk) disable iff (rst)
    strobe.advance |=> !($stable(clockRail) && $stable(dataRail)));  // R6

endmodule

// File: rtl/twoRailEncoder.sv
module twoRailEncoder
  import twoRailPkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dataIn,
  output logic clockRail,
  output logic dataRail
);

  railStrobeT strobe;

  twoRailCtrl #(.RST_STAGES(RST_STAGES)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe)
  );

  twoRailData u_data (
    .clk       (clk),
    .rst       (rst),
    .dataIn    (dataIn),
    .strobe    (strobe),
    .clockRail (clockRail),
    .dataRail  (dataRail)
  );

endmodule

// File: tb/sim_twoRailEncoder.sv
module sim_twoRailEncoder;

  typedef struct {
    logic       r1;
    logic       r2;
    bit         active;
    string      tag;
  } expItemT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dataIn = 1'b0;
  logic clockRail, dataRail;

  int checks = 0;
  int failures = 0;

  expItemT expQ[$];

  // scoreboard model state
  logic mR1 = 1'b0;
  logic mR2 = 1'b0;
  int   mSeq = 2;
  logic [15:0] lfsr = 16'hACE1;

  twoRailEncoder u0 (
    .clk       (clk),
    .rst       (rst),
    .dataIn    (dataIn),
    .clockRail (clockRail),
    .dataRail  (dataRail)
  );

  always #5 clk = ~clk;

  // Driver: set inputs at the falling edge, push the expected rail pair.
  task automatic step(input logic rstVal, input logic bitVal, input string tag,
                      input bit glitch = 1'b0);
    expItemT it;
    @(negedge clk);
    rst    = rstVal;
    dataIn = bitVal;
    it.active = 1'b0;
    if (rstVal) begin
      mR1 = 1'b0; mR2 = 1'b0; mSeq = 2;
    end else if (mSeq > 0) begin
      mSeq = mSeq - 1;
      mR1 = 1'b0; mR2 = 1'b0;
    end else begin
      mR1 = ~mR1;
      if (bitVal) mR2 = ~mR2;
      it.active = 1'b1;
    end
    it.r1 = mR1; it.r2 = mR2; it.tag = tag;
    expQ.push_back(it);
    if (glitch) begin
      logic h1, h2;
      @(posedge clk);
      #3;
      h1 = clockRail; h2 = dataRail;
      dataIn = ~dataIn;
      #1;
      checks++;
      if (clockRail !== h1 || dataRail !== h2) begin
        failures++;
        $display("FAIL R8: rails %b%b after input change, expected %b%b",
                 clockRail, dataRail, h1, h2);
      end
    end
  endtask

  // Monitor: pops one expected item per edge, just after the edge.
  logic prevR1 = 1'b0, prevR2 = 1'b0;
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      expItemT it;
      it = expQ.pop_front();
      checks++;
      if (clockRail !== it.r1 || dataRail !== it.r2) begin
        failures++;
        $display("FAIL %s: rails %b%b, expected %b%b",
                 it.tag, clockRail, dataRail, it.r1, it.r2);
      end
      if (it.active) begin
        checks++;
        if (clockRail === prevR1 && dataRail === prevR2) begin
          failures++;
          $display("FAIL R6: rails %b%b unchanged, expected a transition",
                   clockRail, dataRail);
        end
      end
    end
    prevR1 = clockRail;
    prevR2 = dataRail;
  end

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: held in reset with data toggling
    step(1'b1, 1'b1, "R1");
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b1, "R1");
    // R2: two sequence edges with data 1 must not reach the rails
    step(1'b0, 1'b1, "R2");
    step(1'b0, 1'b1, "R2");
    // R3/R4: run of ones, both rails move together
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, "R4");
    // R3/R5: run of zeros, only the clock rail moves
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, "R5");
    // R3: alternating bits
    for (int i = 0; i < 10; i++) step(1'b0, logic'(i % 2), "R3");
    // pseudo-random stream with between-edge input glitches (R8)
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(1'b0, lfsr[0], "R4", (i % 5) == 2);
    end
    // R7: mid-stream reset, then the sequence repeats
    step(1'b1, 1'b1, "R7");
    step(1'b0, 1'b1, "R7");
    step(1'b0, 1'b1, "R7");
    step(1'b0, 1'b1, "R3");
    step(1'b0, 1'b0, "R5");
    for (int i = 0; i < 20; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(1'b0, lfsr[3], "R5", (i % 4) == 1);
    end
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule